// File: doc/BRIEF.md
# Serial Byte-Exchange Slave with Select Framing

This block is the slave side of a four-wire synchronous serial link. An external master drives the serial clock and an active-low select line. While the slave is selected, it swaps one byte with the master in full duplex: on each serial clock cycle it shifts one bit out on its data output and takes one bit in from its data input. The serial inputs are asynchronous to the block. They are brought into the system clock domain through two-flop synchronizers, and the serial clock edges are found from the synchronized copy.

Both clock polarities and both clock phases are supported. The phase setting decides how the select line frames bytes:

- **Phase 0:** each byte starts at a falling edge of select, so the master must raise select and lower it again between bytes.
- **Phase 1:** select may stay low for a whole burst, and every group of eight clocks is a new byte.

If select is raised in the middle of a byte, the partial byte is dropped and any further clocks are ignored. The data output is driven only while the slave is selected. The pad is tri-stated through a separate enable.

On the parallel side, software loads a transmit byte with a one-cycle strobe. That byte is captured at the start of each serial byte, and it is sent again if no new byte has been loaded. Each completed received byte is presented with a one-cycle valid pulse.

Top module: `spi_target_byte`

## Requirements
- R1: A byte exchange takes eight serial clock cycles, most significant bit first in both directions, and the received byte appears on `rx_byte`.
- R2: `rx_valid` is a single-cycle pulse after the eighth sampling edge, and `rx_byte` changes only together with that pulse.
- R3: `miso_oe` is 1 only while `cfg_en` is 1 and the synchronized `ss_n` is 0.
- R4: Serial clock edges that arrive while `ss_n` is high produce no received byte and do not advance the bit position of the next byte.
- R5: With `cfg_cpha`=0, the fall of `ss_n` starts a byte and puts the first transmit bit on `miso_out` before the first clock edge. Input is sampled on leading edges and output changes on trailing edges.
- R6: With `cfg_cpha`=0, once a byte has completed, further clocks are ignored until `ss_n` has gone high and then low again.
- R7: With `cfg_cpha`=1, output changes on leading edges and input is sampled on trailing edges. `ss_n` may stay low, and each further eight clocks form another byte.
- R8: `cfg_cpol` sets the idle level of `sck_in`. The leading edge is rising when `cfg_cpol`=0 and falling when `cfg_cpol`=1.
- R9: Raising `ss_n` before the eighth sample discards the partial byte: no `rx_valid` is produced, and the next byte starts again from its first bit.
- R10: The byte last written through `tx_load` is captured at the start of every byte. Without a new load, the same byte is sent again.
- R11: With `cfg_en`=0, the block never drives `miso_oe` and never produces `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| sck_in | input | 1 | Serial clock from the master |
| ss_n_in | input | 1 | Active-low select from the master |
| mosi_in | input | 1 | Serial data from the master |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso_out` pad |
| tx_byte | input | DW | Parallel transmit byte |
| tx_load | input | 1 | One-cycle strobe that stores `tx_byte` |
| rx_byte | output | DW | Last completed received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |

## Verification
The assertions rely on the serial clock running at no more than a quarter of the system clock rate. This keeps two sampling edges, and so two `rx_valid` pulses, from landing on adjacent cycles. They also rely on `ss_n` and `mosi` settling in step with `sck`, so that all three pass through their synchronizers together. The stimulus meets both conditions: every serial half-period lasts eight system clocks, and every input is changed on a falling system clock edge. The configuration inputs are changed only while `ss_n` is high.

// File: rtl/spi_target_byte.sv
module spi_target_byte #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          sck_in,
  input  logic          ss_n_in,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic [DW-1:0] tx_byte,
  input  logic          tx_load,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid
);
  localparam int CW = $clog2(DW);

  logic [1:0]    sck_q, ss_q, mosi_q;
  logic          sck_d, ss_d, armed;
  logic [CW-1:0] cnt;
  logic [DW-1:0] tx_hold, tx_sr, rx_sr;

  wire sck_s  = sck_q[1];
  wire ss_s   = ss_q[1];
  wire mosi_s = mosi_q[1];
  wire sel    = cfg_en & ~ss_s;
  wire start  = sel & ss_d & ~cfg_cpha;
  wire sedge  = sel & (sck_s ^ sck_d);
  wire lead   = sedge & (sck_d == cfg_cpol);
  wire trail  = sedge & (sck_d != cfg_cpol);
  wire samp   = cfg_cpha ? trail : lead;
  wire shft   = cfg_cpha ? lead : trail;
  wire live   = cfg_cpha | armed;
  wire last   = (cnt == CW'(DW - 1));
  wire [DW-1:0] rx_next = {rx_sr[DW-2:0], mosi_s};

  assign miso_oe  = sel;
  assign miso_out = tx_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[0], sck_in};
      ss_q   <= {ss_q[0], ss_n_in};
      mosi_q <= {mosi_q[0], mosi_in};
      sck_d  <= sck_s;
      ss_d   <= ss_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_hold <= '0;
    else if (tx_load) tx_hold <= tx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      armed    <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!sel) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (start) begin
        tx_sr <= tx_hold;
        armed <= 1'b1;
        cnt   <= '0;
      end else if (live) begin
        if (shft) begin
          if (cfg_cpha && cnt == '0) tx_sr <= tx_hold;
          else tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end
        if (samp) begin
          rx_sr <= rx_next;
          if (last) begin
            cnt      <= '0;
            armed    <= 1'b0;
            rx_byte  <= rx_next;
            rx_valid <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

module spi_target_byte_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          ss_n_in,
  input logic          miso_oe,
  input logic [DW-1:0] rx_byte,
  input logic          rx_valid
);
  AST_OE_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (cfg_en && !$past(ss_n_in, 2)));                          // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);                                              // R2
  AST_VALID_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(ss_n_in, 3));                                     // R4
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_valid);                                      // R2
  AST_VALID_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(cfg_en));                                          // R11
endmodule

bind spi_target_byte spi_target_byte_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ss_n_in(ss_n_in),
  .miso_oe(miso_oe), .rx_byte(rx_byte), .rx_valid(rx_valid)
);

// File: tb/test_spi_target_byte.sv
`timescale 1ns/1ps
module test_spi_target_byte;
  localparam int HALF = 8;

  logic       clk = 0, rst_n = 0;
  logic       cfg_en = 1, cfg_cpol = 0, cfg_cpha = 0;
  logic       sck = 0, ss_n = 1, mosi = 0, tx_load = 0;
  logic [7:0] tx_byte = 0;
  wire        miso, miso_oe, rx_valid;
  wire  [7:0] rx_byte;

  int errors = 0, checks = 0, nvalid = 0, oe_seen = 0;
  logic [7:0] last_rx = 0, got_miso = 0;
  logic       miso_bad = 0;

  always #5 clk = ~clk;

  spi_target_byte #(.DW(8)) i_spi_target_byte (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .sck_in(sck), .ss_n_in(ss_n), .mosi_in(mosi), .miso_out(miso), .miso_oe(miso_oe),
    .tx_byte(tx_byte), .tx_load(tx_load), .rx_byte(rx_byte), .rx_valid(rx_valid));

  always @(negedge clk) begin
    if (rx_valid) begin nvalid++; last_rx = rx_byte; end
    if (miso_oe) oe_seen++;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); tx_byte = b; tx_load = 1;
    @(negedge clk); tx_load = 0;
  endtask

  task automatic set_mode(input int m);
    ss_n = 1; cfg_cpol = m[1]; cfg_cpha = m[0]; sck = m[1];
    wait_cyc(2 * HALF);
  endtask

  task automatic take_miso(input int i);
    if (!miso_oe) miso_bad = 1;
    got_miso[7-i] = miso;
  endtask

  // shifts nbits of b with ss_n already low
  task automatic bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      if (!cfg_cpha) begin
        mosi = b[7-i];
        wait_cyc(HALF);
        take_miso(i); sck = ~cfg_cpol;
        wait_cyc(HALF);
        sck = cfg_cpol;
      end else begin
        wait_cyc(HALF);
        sck = ~cfg_cpol; mosi = b[7-i];
        wait_cyc(HALF);
        sck = cfg_cpol; take_miso(i);
      end
    end
    wait_cyc(HALF);
  endtask

  task automatic frame(input logic [7:0] b);
    miso_bad = 0; got_miso = 0;
    @(negedge clk); ss_n = 0;
    bits(b, 8);
    ss_n = 1; wait_cyc(2 * HALF);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int nv;
    wait_cyc(4);
    chk(rx_valid == 0 && miso_oe == 0 && rx_byte == 0, "R3 reset",
        {rx_valid, miso_oe, rx_byte}, 0);
    rst_n = 1;
    wait_cyc(4);

    // R1 R5 R7 R8: sweep of all four modes
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      for (int k = 0; k < 6; k++) begin
        logic [7:0] t, r;
        t = 8'((k * 53 + m * 17 + 9) & 255);
        r = 8'((k * 91 + m * 29 + 130) & 255);
        load(t);
        nv = nvalid;
        frame(r);
        chk(nvalid == nv + 1 && last_rx == r, m[0] ? "R7 R1 rx" : "R5 R1 rx", last_rx, r);
        chk(!miso_bad && got_miso == t, m[1] ? "R8 R1 miso" : "R1 miso", got_miso, t);
      end
    end

    // R3: output enable follows select
    set_mode(0);
    chk(miso_oe == 0, "R3 idle", miso_oe, 0);
    @(negedge clk); ss_n = 0; wait_cyc(4);
    chk(miso_oe == 1, "R3 selected", miso_oe, 1);
    ss_n = 1; wait_cyc(4);
    chk(miso_oe == 0, "R3 released", miso_oe, 0);

    // R4: clocks while deselected are ignored
    for (int m = 0; m < 4; m += 3) begin
      set_mode(m);
      nv = nvalid;
      for (int i = 0; i < 5; i++) begin
        sck = ~sck; mosi = ~mosi; wait_cyc(HALF);
        sck = ~sck; wait_cyc(HALF);
      end
      chk(nvalid == nv, "R4 no byte", nvalid, nv);
      load(8'hC3);
      frame(8'h5A);
      chk(nvalid == nv + 1 && last_rx == 8'h5A, "R4 next byte aligned", last_rx, 8'h5A);
    end

    // R9: abort mid-byte
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      load(8'h96);
      nv = nvalid;
      @(negedge clk); ss_n = 0;
      bits(8'hFF, 5);
      ss_n = 1; wait_cyc(2 * HALF);
      chk(nvalid == nv, "R9 partial dropped", nvalid, nv);
      frame(8'h3C);
      chk(nvalid == nv + 1 && last_rx == 8'h3C && got_miso == 8'h96,
          "R9 fresh byte", {last_rx, got_miso}, {8'h3C, 8'h96});
    end

    // R6: phase 0 needs a select toggle per byte
    set_mode(0);
    load(8'h81);
    nv = nvalid;
    @(negedge clk); ss_n = 0;
    bits(8'h11, 8);
    bits(8'h22, 8);
    ss_n = 1; wait_cyc(2 * HALF);
    chk(nvalid == nv + 1 && last_rx == 8'h11, "R6 second byte ignored", nvalid - nv, 1);

    // R7: phase 1 burst under one select, new tx byte between bytes
    set_mode(1);
    load(8'hA5);
    nv = nvalid;
    miso_bad = 0;
    @(negedge clk); ss_n = 0;
    bits(8'h44, 8);
    chk(nvalid == nv + 1 && last_rx == 8'h44 && got_miso == 8'hA5, "R7 burst byte 1",
        {last_rx, got_miso}, {8'h44, 8'hA5});
    load(8'h0F);
    bits(8'hE7, 8);
    chk(nvalid == nv + 2 && last_rx == 8'hE7 && got_miso == 8'h0F && !miso_bad,
        "R7 burst byte 2", {last_rx, got_miso}, {8'hE7, 8'h0F});
    ss_n = 1; wait_cyc(2 * HALF);

    // R10: resend without new load
    for (int m = 0; m < 4; m += 2) begin
      set_mode(m);
      load(8'h6B);
      frame(8'h01);
      frame(8'h02);
      chk(got_miso == 8'h6B, "R10 resend", got_miso, 8'h6B);
    end

    // R11: disabled block stays silent
    set_mode(0);
    cfg_en = 0;
    nv = nvalid; oe_seen = 0;
    frame(8'h77);
    chk(nvalid == nv && oe_seen == 0, "R11 disabled", {nvalid - nv, oe_seen}, 0);
    cfg_en = 1;
    wait_cyc(4);

    summary();
    $finish;
  end
endmodule